// File: doc/BRIEF.md
# Single-Register Pulse-Width Modulator

This block produces one pulse-width modulated output from a single 32-bit control word. The word holds a run bit, a parking level, an 8-bit step length and an 8-bit low-step count. While running, each period is split into 256 steps of equal length, and each step lasts step-length input clocks, so the period is step length × 256 clocks. A step length of zero stands for 256. The output is low for the first low-step-count steps of a period and high for the remaining steps. The low-step count therefore encodes the off fraction in 1/256 units. Software keeps this count between 1 and 255.

Software writes the word through a port with byte enables, so the timing fields can be changed without touching the run and parking bits. The word reads back at all times. The step length and low-step count that the counters use are copied from the word only when the block starts and at each period boundary, so the output never shows a cut-short period. While the block is stopped, the output holds the parking level.

Top module: `pwm_sreg_top`

## Requirements
- R1: While reset is high and on the first cycle after it, the read word is zero and the output is low.
- R2: The field layout is: run at bit 31, parking level at bit 30, step length at bits 15:8, low-step count at bits 7:0. A write updates only the bytes whose enable bit is set (bit k of the enable covers data bits 8k+7:8k). Bits 29:16 always read as zero. The other bits read back as last written, starting from the edge after the write.
- R3: While stopped, the output equals the parking-level bit, starting from the edge that accepts the write.
- R4: While running, one period lasts step length × 256 clocks. A step length of 0 gives 65536 clocks.
- R5: In every period the output is low for the first (low-step count × effective step length) clocks and high for the rest.
- R6: When a write sets the run bit at edge E, the output holds the parking level until edge E+1. From edge E+1 a fresh period starts with both counters at zero.
- R7: A change to step length or low-step count written while running takes effect at the first period boundary after the edge that accepts it. A write accepted on a boundary edge itself waits one further period.
- R8: When a write clears the run bit at edge C, the output shows the parking level from edge C+1. A later restart begins a fresh period as in R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control word |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word |
| pwm_out | output | 1 | Modulated output |

## Verification
The case that needs care is a control-word write that lands on the same edge where the active copies reload at a period boundary. The bench drives low-step-count writes so that they are accepted one edge before the boundary and exactly on the boundary edge. It then compares every output cycle against a waveform computed from the offset of that cycle. In the first case the new count must govern the very next period. In the second case the old count must last for one more full period.

// File: rtl/pwm_sreg_pkg.sv
`timescale 1ns/1ps
package pwm_sreg_pkg;

    localparam int WORD_W   = 32;
    localparam int LANE_W   = 8;
    localparam int LANES    = WORD_W / LANE_W;
    localparam int CNT_W    = 8;
    localparam int RUN_POS  = 31;
    localparam int PARK_POS = 30;
    localparam int LEN_LSB  = CNT_W;
    localparam int LOW_LSB  = 0;

    typedef struct packed {
        logic             run;
        logic             park_lvl;
        logic [CNT_W-1:0] step_len;
        logic [CNT_W-1:0] low_steps;
    } pwm_cfg_t;

    function automatic logic [WORD_W-1:0] live_bits();
        logic [WORD_W-1:0] m;
        m = '0;
        m[RUN_POS]  = 1'b1;
        m[PARK_POS] = 1'b1;
        m[LEN_LSB +: CNT_W] = '1;
        m[LOW_LSB +: CNT_W] = '1;
        return m;
    endfunction

    localparam logic [WORD_W-1:0] LIVE_MASK = live_bits();

    function automatic logic [CNT_W-1:0] last_step(input logic [CNT_W-1:0] len);
        return len - CNT_W'(1);
    endfunction

endpackage

// File: rtl/pwm_sreg_cfg.sv
`timescale 1ns/1ps
module pwm_sreg_cfg
    import pwm_sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_be,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] word_q
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [LANE_W-1:0] LMASK = LIVE_MASK[LANE_W*g +: LANE_W];
        logic [LANE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q <= '0;
            end else if (wr_en && wr_be[g]) begin
                lane_q <= wr_data[LANE_W*g +: LANE_W] & LMASK;
            end
        end

        assign word_q[LANE_W*g +: LANE_W] = lane_q;
    end

    assert_full_readback_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (&wr_be)) |=> (word_q == ($past(wr_data) & LIVE_MASK)));

    assert_no_write_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |=> $stable(word_q));

endmodule

// File: rtl/pwm_sreg_prescale.sv
`timescale 1ns/1ps
module pwm_sreg_prescale
    import pwm_sreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] step_len,
    output logic             tick,
    output logic [CNT_W-1:0] cnt
);

    // A step length of zero wraps to an all-ones terminal count: 256 clocks.
    assign tick = run && (cnt == last_step(step_len));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assert_tick_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0));

    assert_count_advance_R4: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> (cnt == $past(cnt) + CNT_W'(1)));

endmodule

// File: rtl/pwm_sreg_phase.sv
`timescale 1ns/1ps
module pwm_sreg_phase
    import pwm_sreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] cfg_len,
    input  logic [CNT_W-1:0] cfg_low,
    output logic [CNT_W-1:0] len_act,
    output logic [CNT_W-1:0] phase,
    output logic             wave
);

    logic [CNT_W-1:0] low_act;
    logic             wrap;

    assign wrap = tick && (phase == '1);
    assign wave = (phase >= low_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= '0;
            len_act <= '0;
            low_act <= '0;
        end else if (!run) begin
            phase   <= '0;
            len_act <= cfg_len;
            low_act <= cfg_low;
        end else begin
            if (tick) begin
                phase <= phase + CNT_W'(1);
            end
            if (wrap) begin
                len_act <= cfg_len;
                low_act <= cfg_low;
            end
        end
    end

    assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (run && !wrap) |=> ($stable(low_act) && $stable(len_act)));

    assert_phase_step_R5: assert property (@(posedge clk) disable iff (rst)
        (run && tick) |=> (phase == $past(phase) + CNT_W'(1)));

    assert_phase_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(phase));

endmodule

// File: rtl/pwm_sreg_top.sv
`timescale 1ns/1ps
module pwm_sreg_top
    import pwm_sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_be,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              pwm_out
);

    logic [WORD_W-1:0] word_q;
    pwm_cfg_t          cfg;
    logic              run_q;
    logic              tick;
    logic [CNT_W-1:0]  pre_cnt;
    logic [CNT_W-1:0]  len_act;
    logic [CNT_W-1:0]  phase;
    logic              wave;

    pwm_sreg_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .word_q  (word_q)
    );

    assign cfg.run       = word_q[RUN_POS];
    assign cfg.park_lvl  = word_q[PARK_POS];
    assign cfg.step_len  = word_q[LEN_LSB +: CNT_W];
    assign cfg.low_steps = word_q[LOW_LSB +: CNT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
        end else begin
            run_q <= cfg.run;
        end
    end

    pwm_sreg_prescale u_pre (
        .clk      (clk),
        .rst      (rst),
        .run      (run_q),
        .step_len (len_act),
        .tick     (tick),
        .cnt      (pre_cnt)
    );

    pwm_sreg_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .run     (run_q),
        .tick    (tick),
        .cfg_len (cfg.step_len),
        .cfg_low (cfg.low_steps),
        .len_act (len_act),
        .phase   (phase),
        .wave    (wave)
    );

    assign rd_data = word_q;
    assign pwm_out = run_q ? wave : cfg.park_lvl;

    assert_fresh_start_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(run_q) |-> ((phase == '0) && (pre_cnt == '0)));

    assert_parked_output_R8: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[RUN_POS] && !$past(rd_data[RUN_POS])) |-> (pwm_out == rd_data[PARK_POS]));

    assert_dead_bits_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((rd_data & ~LIVE_MASK) == '0));

endmodule

// File: tb/pwm_sreg_top_tb_top.sv
`timescale 1ns/1ps
module pwm_sreg_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = 4'h0;
    logic [31:0] wr_data = 32'h0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pwm_sreg_top dut_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_wave(input int t, input int r, input int d);
        int re = (r == 0) ? 256 : r;
        int p  = 256 * re;
        int ph = (t % p) / re;
        return (ph >= d);
    endfunction

    // Returns just after the accepting edge, before the next one.
    task automatic reg_write(input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0; wr_be = 4'h0;
    endtask

    // Enable write, then check the parked level before the first running edge.
    task automatic start_run(input logic park, input string req);
        reg_write(4'h8, {1'b1, park, 30'h0});
        @(negedge clk);
        check(pwm_out === park, req, "parked before first running edge", pwm_out, park);
        check(rd_data[31] === 1'b1, "R2", "run bit readback", rd_data[31], 1);
    endtask

    // Compare n cycles against the computed waveform; optional mid-run write at offset wr_t.
    task automatic window(input int r1, input int d1, input int r2, input int d2,
                          input int wr_t, input int n, input string req);
        int bad_cnt = 0;
        int first_t = -1;
        logic fa = 1'b0;
        logic fe = 1'b0;
        int re1 = (r1 == 0) ? 256 : r1;
        int p1  = 256 * re1;
        int sw  = (wr_t < 0) ? n + 1 : (((wr_t + 1) / p1) + 1) * p1;
        for (int t = 0; t < n; t++) begin
            logic e;
            @(negedge clk);
            e = (t < sw) ? exp_wave(t, r1, d1) : exp_wave(t - sw, r2, d2);
            if (pwm_out !== e) begin
                bad_cnt++;
                if (first_t < 0) begin first_t = t; fa = pwm_out; fe = e; end
            end
            if (t == wr_t) begin
                wr_en = 1'b1; wr_be = 4'h3;
                wr_data = {16'h0, r2[7:0], d2[7:0]};
            end else begin
                wr_en = 1'b0; wr_be = 4'h0;
            end
        end
        wr_en = 1'b0;
        check(bad_cnt == 0, req,
              $sformatf("waveform len=%0d low=%0d first bad offset %0d", r1, d1, first_t),
              fa, fe);
    endtask

    task automatic stop_run(input logic park);
        reg_write(4'h8, {1'b0, park, 30'h0});
        @(posedge clk);
        @(negedge clk);
        check(pwm_out === park, "R8", "parked after stop", pwm_out, park);
    endtask

    initial begin
        #1_900_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int lows[6] = '{1, 2, 64, 128, 200, 255};

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rd_data === 32'h0, "R1", "word during reset", rd_data, 0);
        check(pwm_out === 1'b0, "R1", "output during reset", pwm_out, 0);
        rst = 1'b0;
        @(negedge clk);
        check(rd_data === 32'h0, "R1", "word after reset", rd_data, 0);
        check(pwm_out === 1'b0, "R1", "output after reset", pwm_out, 0);

        // R3: parking level follows bit 30 while stopped
        reg_write(4'h8, 32'h4000_0000);
        @(negedge clk);
        check(pwm_out === 1'b1, "R3", "park high", pwm_out, 1);
        check(rd_data === 32'h4000_0000, "R2", "park bit readback", rd_data, 32'h4000_0000);

        // R2: byte lanes and dead bits
        reg_write(4'hF, 32'h7FFF_FFFF);
        @(negedge clk);
        check(rd_data === 32'h4000_FFFF, "R2", "full write masks 29:16", rd_data, 32'h4000_FFFF);
        check(pwm_out === 1'b1, "R3", "still parked after full write", pwm_out, 1);
        reg_write(4'h2, 32'hFFFF_12FF);
        @(negedge clk);
        check(rd_data === 32'h4000_12FF, "R2", "lane 1 only", rd_data, 32'h4000_12FF);
        reg_write(4'h4, 32'hFFFF_FFFF);
        @(negedge clk);
        check(rd_data === 32'h4000_12FF, "R2", "lane 2 has no live bits", rd_data, 32'h4000_12FF);
        reg_write(4'h1, 32'h0000_0000);
        @(negedge clk);
        check(rd_data === 32'h4000_1200, "R2", "lane 0 only", rd_data, 32'h4000_1200);
        reg_write(4'h8, 32'h0000_0000);
        @(negedge clk);
        check(pwm_out === 1'b0, "R3", "park low", pwm_out, 0);

        // R5/R6: sweep of low-step counts, step length 1
        foreach (lows[i]) begin
            reg_write(4'h3, {16'h0, 8'd1, lows[i][7:0]});
            start_run(1'b0, "R6");
            window(1, lows[i], 1, lows[i], -1, 512, "R5");
            stop_run(1'b0);
        end

        // R4/R5: longer steps
        reg_write(4'h3, {16'h0, 8'd3, 8'd85});
        start_run(1'b0, "R6");
        window(3, 85, 3, 85, -1, 1536, "R4");
        stop_run(1'b0);
        reg_write(4'h3, {16'h0, 8'd2, 8'd170});
        start_run(1'b0, "R6");
        window(2, 170, 2, 170, -1, 1100, "R5");
        stop_run(1'b0);

        // R4: step length 0 means 256
        reg_write(4'h3, {16'h0, 8'd0, 8'd128});
        start_run(1'b0, "R6");
        window(0, 128, 0, 128, -1, 65536 + 600, "R4");
        stop_run(1'b0);

        // R7: write mid-period, one edge before the boundary, and on the boundary
        reg_write(4'h3, {16'h0, 8'd1, 8'd64});
        start_run(1'b0, "R6");
        window(1, 64, 1, 192, 100, 768, "R7");
        stop_run(1'b0);
        reg_write(4'h3, {16'h0, 8'd1, 8'd64});
        start_run(1'b0, "R6");
        window(1, 64, 1, 10, 254, 768, "R7");
        stop_run(1'b0);
        reg_write(4'h3, {16'h0, 8'd1, 8'd64});
        start_run(1'b0, "R6");
        window(1, 64, 2, 32, 255, 1536, "R7");
        check(rd_data === 32'h8000_0220, "R2", "timing lanes keep run bit", rd_data, 32'h8000_0220);

        // R8/R6: stop mid-period with park high, then restart from phase zero
        stop_run(1'b1);
        start_run(1'b1, "R6");
        window(2, 32, 2, 32, -1, 1024, "R6");
        stop_run(1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule